// File: doc/BRIEF.md
# Embedded Controller Host-Port Handshake

This block is the controller side of a byte-wide host port with two locations: a data port and a combined status/command port. The host places command bytes on the command port and address or data bytes on the data port. Each byte it writes raises an input-full flag. The block consumes the byte a fixed number of cycles later and then clears the flag. When the block has a byte ready for the host it raises an output-full flag. A read of the data port clears that flag.

Commands are multi-byte sequences. A read takes one address byte and returns that register's value on the data port. A write takes an address byte and then a data byte and commits it. A query returns the pending event code. Two further commands set and clear a burst flag. The 256-entry register space sits outside the block. It is reached through a read port and a write port that share one address bus. The read data is expected in the same cycle. The host is expected to poll the status byte. It waits for input-full to clear before each write and for output-full to set before each data read.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and the data port reads 0x00.
- R2: A host write to either port sets input-full (status bit 1) on the next cycle. The flag stays set for exactly CONSUME_LAT cycles. Status bit 3 reads 1 when the last accepted byte went to the command port (host_a2=1) and 0 when it went to the data port.
- R3: A host write made while input-full is set is ignored.
- R4: Command 0x80 followed by an address byte loads the register at that address into the data port and sets output-full (status bit 0).
- R5: A host read of the data port clears output-full. A strobed read of the status port leaves it set.
- R6: Command 0x81 followed by an address byte and a data byte performs exactly one register write of that data to that address.
- R7: Command 0x82 sets the burst flag (status bit 4), and command 0x83 clears it.
- R8: Command 0x84 loads evt_code into the data port and sets output-full. evt_code is 0 when no event is pending.
- R9: A command byte other than 0x80 to 0x84 is discarded. The data bytes that follow cause no register access and no output.
- R10: A data byte received while no command sequence is open is discarded.
- R11: A command byte received in the middle of a read or write sequence abandons that sequence. The new command then takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_a2 | input | 1 | Port select: 0 = data port, 1 = status/command port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Data port byte or status byte, selected by host_a2 |
| reg_addr | output | 8 | Register-space address for both ports |
| reg_re | output | 1 | Register read in this cycle |
| reg_rdata | input | 8 | Register read data, valid in the same cycle |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| evt_code | input | 8 | Pending event code returned by a query, 0 when none |

## Verification
The bench builds the block with CONSUME_LAT set to 3. With that value, a second write can land inside the busy window, and the length of the input-full pulse can be counted directly. At this small latency a full protocol transaction takes about fifteen cycles. That makes it cheap to write all 256 register addresses through the command sequence and then read every one back, with values computed arithmetically in the bench. The bench also sweeps a range of undefined command codes.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_READ      = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_WRITE     = 8'h81;
  localparam logic [BYTE_W-1:0] CMD_BURST_ON  = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_BURST_OFF = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_QUERY     = 8'h84;

  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD_ADDR,
    SEQ_WR_ADDR,
    SEQ_WR_DATA
  } seq_state_t;

  // Assemble the host-visible status byte from the handshake flags.
  function automatic logic [BYTE_W-1:0] pack_status(input logic obf, input logic ibf,
                                                    input logic cmd, input logic burst);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_OBF]   = obf;
    s[ST_IBF]   = ibf;
    s[ST_CMD]   = cmd;
    s[ST_BURST] = burst;
    return s;
  endfunction

  // Sequencer state opened by a command byte; everything else returns to idle.
  function automatic seq_state_t cmd_next_state(input logic [BYTE_W-1:0] code);
    case (code)
      CMD_READ:  return SEQ_RD_ADDR;
      CMD_WRITE: return SEQ_WR_ADDR;
      default:   return SEQ_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/ec_in_buffer.sv
module ec_in_buffer
  import ec_port_pkg::*;
#(
  parameter int CONSUME_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              ibf,
  output logic              is_cmd,
  output logic [BYTE_W-1:0] in_byte,
  output logic              consume
);
  localparam int CNT_W = (CONSUME_LAT > 1) ? $clog2(CONSUME_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONSUME_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept  = wr_stb && !ibf;
  assign consume = ibf && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf     <= 1'b0;
      is_cmd  <= 1'b0;
      in_byte <= '0;
      cnt     <= '0;
    end else if (accept) begin
      ibf     <= 1'b1;
      is_cmd  <= wr_is_cmd;
      in_byte <= wr_byte;
      cnt     <= CNT_LOAD;
    end else if (consume) begin
      ibf <= 1'b0;
    end else if (ibf) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ibf);
  // R3
  ibf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !consume) |=> (ibf && $stable(in_byte) && $stable(is_cmd)));
  // R2
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !ibf);
endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              is_cmd,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic [BYTE_W-1:0] evt_code,
  output logic              reg_we,
  output logic              reg_re,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              burst,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte
);
  seq_state_t        state, state_nxt;
  logic [BYTE_W-1:0] addr_q;
  logic              burst_nxt;
  logic              addr_capture;

  always_comb begin
    state_nxt    = state;
    burst_nxt    = burst;
    reg_we       = 1'b0;
    reg_re       = 1'b0;
    reg_addr     = addr_q;
    reg_wdata    = in_byte;
    load         = 1'b0;
    load_byte    = reg_rdata;
    addr_capture = 1'b0;
    if (consume) begin
      if (is_cmd) begin
        // R11: any command restarts the sequencer
        state_nxt = cmd_next_state(in_byte);
        case (in_byte)
          CMD_BURST_ON:  burst_nxt = 1'b1;
          CMD_BURST_OFF: burst_nxt = 1'b0;
          CMD_QUERY: begin
            load      = 1'b1;
            load_byte = evt_code;
          end
          default: ;
        endcase
      end else begin
        case (state)
          SEQ_RD_ADDR: begin
            reg_re    = 1'b1;
            reg_addr  = in_byte;
            load      = 1'b1;
            load_byte = reg_rdata;
            state_nxt = SEQ_IDLE;
          end
          SEQ_WR_ADDR: begin
            addr_capture = 1'b1;
            state_nxt    = SEQ_WR_DATA;
          end
          SEQ_WR_DATA: begin
            reg_we    = 1'b1;
            state_nxt = SEQ_IDLE;
          end
          default: ;  // R10: stray data byte
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      burst  <= 1'b0;
      addr_q <= '0;
    end else begin
      state <= state_nxt;
      burst <= burst_nxt;
      if (addr_capture) addr_q <= in_byte;
    end
  end

  // R6
  reg_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re}));
  // R6
  write_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (state == SEQ_IDLE));
  // R7
  burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && is_cmd && in_byte == CMD_BURST_ON) |=> burst);
  // R7
  burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && is_cmd && in_byte == CMD_BURST_OFF) |=> !burst);
  // R10
  stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !is_cmd && state == SEQ_IDLE) |-> (!reg_we && !reg_re && !load));
endmodule

// File: rtl/ec_out_buffer.sv
module ec_out_buffer
  import ec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              host_rd,
  output logic              obf,
  output logic [BYTE_W-1:0] out_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      out_byte <= '0;
    end else if (load) begin
      obf      <= 1'b1;
      out_byte <= load_byte;
    end else if (host_rd) begin
      obf <= 1'b0;
    end
  end

  // R4
  obf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (obf && out_byte == $past(load_byte)));
  // R5
  obf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !load) |=> !obf);
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_port_pkg::*;
#(
  parameter int CONSUME_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_a2,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] reg_addr,
  output logic       reg_re,
  input  logic [7:0] reg_rdata,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] evt_code
);
  logic              wr_stb, rd_data_stb;
  logic              ibf, is_cmd, consume;
  logic [BYTE_W-1:0] in_byte;
  logic              burst, load, obf;
  logic [BYTE_W-1:0] load_byte, out_byte;

  assign wr_stb      = host_sel && host_wr;
  assign rd_data_stb = host_sel && !host_wr && !host_a2;

  ec_in_buffer #(.CONSUME_LAT(CONSUME_LAT)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_is_cmd(host_a2), .wr_byte(host_wdata),
    .ibf(ibf), .is_cmd(is_cmd), .in_byte(in_byte), .consume(consume)
  );

  ec_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .consume(consume), .is_cmd(is_cmd), .in_byte(in_byte),
    .reg_rdata(reg_rdata), .evt_code(evt_code), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .burst(burst), .load(load),
    .load_byte(load_byte)
  );

  ec_out_buffer u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte), .host_rd(rd_data_stb),
    .obf(obf), .out_byte(out_byte)
  );

  assign host_rdata = host_a2 ? pack_status(obf, ibf, is_cmd, burst) : out_byte;

  // R5
  status_read_keeps_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_a2 && obf) |=> obf);
  // R3
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ibf && !consume) |=> (ibf && $stable(in_byte)));
endmodule

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, host_sel, host_wr, host_a2;
  logic [7:0] host_wdata, host_rdata, reg_addr, reg_wdata, reg_rdata, evt_code;
  logic       reg_re, reg_we;

  int checks = 0;
  int failures = 0;
  int we_count = 0;
  logic [7:0] mem [256];

  ec_host_port #(.CONSUME_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_a2(host_a2),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .reg_addr(reg_addr), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata), .evt_code(evt_code)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count      <= we_count + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 29 + 11) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic peek_status(output logic [7:0] s);
    host_a2 = 1'b1;
    #1 s = host_rdata;
  endtask

  task automatic host_write(input bit a2, input logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_a2 = a2; host_wdata = v;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic wait_ibf();
    logic [7:0] s;
    peek_status(s);
    while (s[1]) begin
      @(negedge clk);
      peek_status(s);
    end
  endtask

  task automatic send(input bit a2, input logic [7:0] v);
    host_write(a2, v);
    wait_ibf();
  endtask

  task automatic host_read(input bit a2, output logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_a2 = a2;
    #1 v = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    int n, wc;
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_a2 = 1'b0;
    host_wdata = 8'h00; evt_code = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek_status(s);
    check(s == 8'h00, "R1 status after reset", s, 8'h00);
    host_a2 = 1'b0; #1;
    check(host_rdata == 8'h00, "R1 data after reset", host_rdata, 8'h00);

    // R2 flag timing on a command write
    host_write(1'b1, 8'h83);
    peek_status(s);
    check(s == 8'h0A, "R2 status after command write", s, 8'h0A);
    n = 0;
    while (s[1]) begin @(negedge clk); n++; peek_status(s); end
    check(n == LAT, "R2 input-full duration", n, LAT);

    // R2 / R10 stray data byte
    wc = we_count;
    host_write(1'b0, 8'h5A);
    peek_status(s);
    check(s == 8'h02, "R2 status after data write", s, 8'h02);
    wait_ibf();
    peek_status(s);
    check(s == 8'h00, "R10 stray data leaves no output", s, 8'h00);
    check(we_count == wc, "R10 stray data no register write", we_count, wc);

    // R3 write during busy window is dropped; R7 burst on
    host_write(1'b1, 8'h82);
    host_write(1'b1, 8'h83);
    wait_ibf();
    peek_status(s);
    check(s == 8'h18, "R3 busy write ignored, burst on", s, 8'h18);
    send(1'b1, 8'h83);
    peek_status(s);
    check(s == 8'h08, "R7 burst off", s, 8'h08);

    // R8 query with no event
    evt_code = 8'h00;
    send(1'b1, 8'h84);
    peek_status(s);
    check(s[0] == 1'b1, "R8 query sets output-full", s[0], 1);
    host_read(1'b0, v);
    check(v == 8'h00, "R8 query no event", v, 8'h00);

    // R8 / R5 query with event, status strobe keeps flag
    evt_code = 8'hA5;
    send(1'b1, 8'h84);
    host_read(1'b1, s);
    peek_status(s);
    check(s[0] == 1'b1, "R5 status read keeps output-full", s[0], 1);
    host_read(1'b0, v);
    check(v == 8'hA5, "R8 query returns event code", v, 8'hA5);
    peek_status(s);
    check(s[0] == 1'b0, "R5 data read clears output-full", s[0], 0);

    // R9 unknown commands discarded
    for (int c = 8'h85; c <= 8'h8F; c++) begin
      wc = we_count;
      send(1'b1, 8'(c));
      send(1'b0, 8'h10);
      send(1'b0, 8'h20);
      peek_status(s);
      check(s[0] == 1'b0, "R9 unknown command no output", s[0], 0);
      check(we_count == wc, "R9 unknown command no write", we_count, wc);
    end

    // R11 command mid-sequence
    send(1'b1, 8'h81); send(1'b0, 8'h10); send(1'b0, 8'h66);
    evt_code = 8'h3C;
    send(1'b1, 8'h81); send(1'b0, 8'h10);
    send(1'b1, 8'h84);
    send(1'b0, 8'h99);
    check(mem[8'h10] == 8'h66, "R11 abandoned write", mem[8'h10], 8'h66);
    host_read(1'b0, v);
    check(v == 8'h3C, "R11 new command effective", v, 8'h3C);

    // R6 write every address
    for (int a = 0; a < 256; a++) begin
      wc = we_count;
      send(1'b1, 8'h81); send(1'b0, 8'(a)); send(1'b0, pattern(a));
      check(mem[a] == pattern(a), "R6 register write data", mem[a], pattern(a));
      check(we_count == wc + 1, "R6 single write strobe", we_count, wc + 1);
    end

    // R4 read every address back
    for (int a = 0; a < 256; a++) begin
      send(1'b1, 8'h80); send(1'b0, 8'(a));
      peek_status(s);
      check(s[0] == 1'b1, "R4 read sets output-full", s[0], 1);
      host_read(1'b0, v);
      check(v == pattern(a), "R4 read data", v, pattern(a));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule